// File: doc/BRIEF.md
# Windowed Speech Autocorrelation Engine

This block sits at the front of a linear-prediction speech analyser. It accepts 16-bit speech samples over a valid/ready stream and keeps the most recent 240 of them (30 ms at 8 kHz) in a circular store. When a frame strobe arrives, usually once every 80 new samples, it weights the stored samples with a fixed asymmetric analysis window and computes the autocorrelation lags r(0) to r(10) of the weighted signal.

The window rises along the first half of a Hamming shape over 200 points. It then falls along a quarter cosine cycle over the last 40 points, so the most recent samples carry more weight than the oldest. The weights are Q15 constants generated when the design is elaborated. All product sums go through one multiply-accumulate unit, one lag after another. Each finished lag leaves on a result port tagged with its lag number, and a done pulse closes the analysis. A strobe that arrives while an analysis is running is remembered and starts the next analysis as soon as the current one finishes.

Top module: `lpc_autocorr`

## Requirements
- R1: After reset, ac_valid and done are 0 and in_ready is 1. Every location of the sample store holds 0.
- R2: An analysis uses the last 240 accepted samples. Window index 0 is the oldest of them and index 239 the newest. Stored zeros stand in for samples not yet received.
- R3: The weight w(n) is the Q15 value round(32768·v), limited to 32767. For n from 0 to 199, v = 0.54 − 0.46·cos(2πn/399). For n from 200 to 239, v = cos(2π(n−200)/159).
- R4: The windowed sample is y(n) = (x(n)·w(n) + 16384) >> 15, with an arithmetic shift, kept as 16 signed bits.
- R5: Lag k is the sum over n from k to 239 of y(n)·y(n−k). It is carried in 40-bit two's complement and never wraps, even for full-scale input.
- R6: Each analysis produces exactly 11 results, one per cycle in which ac_valid is 1. ac_lag counts 0,1,…,10 in that order, and ac_value holds the lag.
- R7: done is a one-cycle pulse. It comes in the cycle after the lag-10 result.
- R8: A sample is accepted only in a cycle with in_valid and in_ready both 1. in_ready is 0 in the cycle that launches an analysis and during the 240 windowing cycles, so samples offered then are not stored. in_ready is 1 while lags are being accumulated.
- R9: A frame_start received while an analysis is running is held. It starts a new analysis on the same stored samples right after the current one. Several such strobes in one analysis give only one further analysis.
- R10: A frame_start while idle starts an analysis. The first ac_valid follows after 240 windowing cycles plus 240 accumulation cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Signed speech sample |
| frame_start | input | 1 | Request an analysis of the stored samples |
| ac_valid | output | 1 | ac_lag and ac_value hold a result |
| ac_lag | output | 4 | Lag number of the result |
| ac_value | output | 40 | Signed autocorrelation value |
| done | output | 1 | Pulse after the last lag of an analysis |

## Verification
Some properties are checked on every cycle. Results must come in lag order without gaps, exactly 11 results must come before each done, and r(0) must never be negative. The write pointer must not move while windowing, and a pending request must never stay unserved while the block is idle. Some behaviour can only be shown by the bench's scenarios comparing all 11 lags against an independent model: the window values, the rounding, overlap across frames, zero fill after reset, rejection of samples offered while windowing, and full-scale inputs that would wrap a narrower accumulator. The pending-strobe scenario shows that several strobes collapse into one extra analysis.

// File: rtl/lpc_ac_pkg.sv
package lpc_ac_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int ACCUM_W   = 40;
    localparam int SPAN_LEN  = 240;
    localparam int RISE_LEN  = 200;
    localparam int LAG_COUNT = 11;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WEIGHT,
        PH_CORR
    } phase_e;

    localparam real TWO_PI = 6.283185307179586;

    // Q15 weight for window index n: rising half-Hamming then falling quarter cosine.
    function automatic logic [15:0] weight_q15(input int n, input int rise, input int span);
        real v;
        int  q;
        if (n < rise)
            v = 0.54 - 0.46 * $cos(TWO_PI * real'(n) / real'(2 * rise - 1));
        else
            v = $cos(TWO_PI * real'(n - rise) / real'(4 * (span - rise) - 1));
        q = $rtoi(v * 32768.0 + 0.5);
        if (q > 32767) q = 32767;
        if (q < 0) q = 0;
        return 16'(q);
    endfunction

endpackage

// File: rtl/lpc_win_rom.sv
module lpc_win_rom #(
    parameter int SPAN = lpc_ac_pkg::SPAN_LEN,
    parameter int RISE = lpc_ac_pkg::RISE_LEN,
    parameter int AW   = $clog2(SPAN)
) (
    input  logic [AW-1:0] addr,
    output logic [15:0]   coef
);
    logic [15:0] table_q [SPAN];

    for (genvar i = 0; i < SPAN; i++) begin : g_entry
        localparam logic [15:0] WVAL = lpc_ac_pkg::weight_q15(i, RISE, SPAN);
        assign table_q[i] = WVAL;
    end

    always_comb begin
        coef = '0;
        if (int'(addr) < SPAN) coef = table_q[addr];
    end
endmodule

// File: rtl/lpc_sample_ring.sv
module lpc_sample_ring #(
    parameter int DW    = lpc_ac_pkg::SAMPLE_W,
    parameter int DEPTH = lpc_ac_pkg::SPAN_LEN,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [DW-1:0] rd_data,
    output logic [AW-1:0]        wr_ptr
);
    logic signed [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[wr_ptr] <= wr_data;
            wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/lpc_mac.sv
module lpc_mac #(
    parameter int DW = lpc_ac_pkg::SAMPLE_W,
    parameter int AccW = lpc_ac_pkg::ACCUM_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   clr,
    input  logic signed [DW-1:0]   a,
    input  logic signed [DW-1:0]   b,
    output logic signed [AccW-1:0] sum
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0]   prod;
    logic signed [AccW-1:0] acc;

    assign prod = a * b;
    assign sum  = acc + {{(AccW - PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (en)    acc <= sum;
    end
endmodule

// File: rtl/lpc_autocorr.sv
module lpc_autocorr
    import lpc_ac_pkg::*;
#(
    parameter int DW    = SAMPLE_W,
    parameter int AccW  = ACCUM_W,
    parameter int SPAN  = SPAN_LEN,
    parameter int RISE  = RISE_LEN,
    parameter int NLAGS = LAG_COUNT,
    localparam int AW   = $clog2(SPAN),
    localparam int LW   = $clog2(NLAGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [DW-1:0]          in_sample,
    input  logic                   frame_start,
    output logic                   ac_valid,
    output logic [LW-1:0]          ac_lag,
    output logic [AccW-1:0]        ac_value,
    output logic                   done
);
    localparam logic [AW-1:0] LAST_N = AW'(SPAN - 1);
    localparam logic [LW-1:0] LAST_K = LW'(NLAGS - 1);

    phase_e               state;
    logic [AW-1:0]        n_idx;
    logic [LW-1:0]        k_idx;
    logic [AW-1:0]        base;
    logic                 pend;
    logic [AW-1:0]        wr_ptr;
    logic [AW-1:0]        rd_addr;
    logic [AW:0]          rd_sum;
    logic signed [DW-1:0] rd_data;
    logic [15:0]          coef;
    logic signed [DW+16:0] wprod;
    logic signed [DW+16:0] wrnd;
    logic signed [DW-1:0] wval;
    logic signed [DW-1:0] wbuf [SPAN];
    logic signed [DW-1:0] mac_a;
    logic signed [DW-1:0] mac_b;
    logic signed [AccW-1:0] mac_sum;
    logic                 launch;
    logic                 lag_end;

    assign launch   = (state == PH_IDLE) && (frame_start || pend);
    assign lag_end  = (state == PH_CORR) && (n_idx == LAST_N);
    assign in_ready = (state == PH_CORR) || ((state == PH_IDLE) && !frame_start && !pend);

    lpc_sample_ring #(.DW(DW), .DEPTH(SPAN), .AW(AW)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid && in_ready),
        .wr_data (in_sample),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_ptr  (wr_ptr)
    );

    lpc_win_rom #(.SPAN(SPAN), .RISE(RISE), .AW(AW)) u_rom (
        .addr (n_idx),
        .coef (coef)
    );

    // oldest sample sits at the write pointer captured at launch
    always_comb begin
        rd_sum  = {1'b0, base} + {1'b0, n_idx};
        rd_addr = (rd_sum >= (AW+1)'(SPAN)) ? AW'(rd_sum - (AW+1)'(SPAN)) : rd_sum[AW-1:0];
    end

    assign wprod = (DW+17)'(rd_data) * (DW+17)'(signed'({1'b0, coef}));
    assign wrnd  = wprod + (DW+17)'(16384);
    assign wval  = DW'(wrnd >>> 15);

    always_ff @(posedge clk) begin
        if (state == PH_WEIGHT) wbuf[n_idx] <= wval;
    end

    assign mac_a = wbuf[n_idx];
    assign mac_b = wbuf[n_idx - AW'(k_idx)];

    lpc_mac #(.DW(DW), .AccW(AccW)) u_mac (
        .clk (clk),
        .rst (rst),
        .en  (state == PH_CORR),
        .clr (lag_end || (state != PH_CORR)),
        .a   (mac_a),
        .b   (mac_b),
        .sum (mac_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_IDLE;
            n_idx    <= '0;
            k_idx    <= '0;
            base     <= '0;
            pend     <= 1'b0;
            ac_valid <= 1'b0;
            ac_lag   <= '0;
            ac_value <= '0;
            done     <= 1'b0;
        end else begin
            ac_valid <= 1'b0;
            done     <= ac_valid && (ac_lag == LAST_K);
            if (frame_start && state != PH_IDLE) pend <= 1'b1;
            unique case (state)
                PH_IDLE: begin
                    if (launch) begin
                        state <= PH_WEIGHT;
                        base  <= wr_ptr;
                        n_idx <= '0;
                        pend  <= 1'b0;
                    end
                end
                PH_WEIGHT: begin
                    if (n_idx == LAST_N) begin
                        state <= PH_CORR;
                        n_idx <= '0;
                        k_idx <= '0;
                    end else begin
                        n_idx <= n_idx + 1'b1;
                    end
                end
                PH_CORR: begin
                    if (lag_end) begin
                        ac_valid <= 1'b1;
                        ac_lag   <= k_idx;
                        ac_value <= mac_sum;
                        if (k_idx == LAST_K) begin
                            state <= PH_IDLE;
                        end else begin
                            k_idx <= k_idx + 1'b1;
                            n_idx <= AW'(k_idx) + 1'b1;
                        end
                    end else begin
                        n_idx <= n_idx + 1'b1;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lpc_ac_checker.sv
module lpc_ac_checker
    import lpc_ac_pkg::*;
#(
    parameter int AccW  = ACCUM_W,
    parameter int SPAN  = SPAN_LEN,
    parameter int NLAGS = LAG_COUNT,
    localparam int AW   = $clog2(SPAN),
    localparam int LW   = $clog2(NLAGS)
) (
    input logic            clk,
    input logic            rst,
    input logic            ac_valid,
    input logic [LW-1:0]   ac_lag,
    input logic [AccW-1:0] ac_value,
    input logic            done,
    input phase_e          state,
    input logic            pend,
    input logic [AW-1:0]   wr_ptr
);
    logic [LW-1:0] want_lag;
    logic [LW:0]   seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            want_lag <= '0;
            seen     <= '0;
        end else begin
            if (ac_valid) begin
                want_lag <= (ac_lag == LW'(NLAGS - 1)) ? '0 : want_lag + 1'b1;
                seen     <= seen + 1'b1;
            end else if (done) begin
                seen <= '0;
            end
        end
    end

    assert_lag_order_R6: assert property (@(posedge clk) disable iff (rst)
        ac_valid |-> (ac_lag == want_lag));

    assert_done_count_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen == (LW+1)'(NLAGS)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_lag0_nonneg_R5: assert property (@(posedge clk) disable iff (rst)
        (ac_valid && ac_lag == '0) |-> !ac_value[AccW-1]);

    assert_ptr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PH_WEIGHT) |=> $stable(wr_ptr));

    assert_no_idle_pending_R9: assert property (@(posedge clk) disable iff (rst)
        (state == PH_IDLE && pend) |=> (state == PH_WEIGHT));
endmodule

bind lpc_autocorr lpc_ac_checker #(
    .AccW(AccW), .SPAN(SPAN), .NLAGS(NLAGS)
) u_ac_checker (
    .clk(clk), .rst(rst), .ac_valid(ac_valid), .ac_lag(ac_lag),
    .ac_value(ac_value), .done(done), .state(state), .pend(pend), .wr_ptr(wr_ptr)
);

// File: tb/test_lpc_autocorr.sv
module test_lpc_autocorr;
    localparam int NL = 11;
    localparam int WN = 240;
    localparam real PI2 = 6.283185307179586;

    typedef struct packed {
        logic [1:0]         kind;   // 0 random, 1 sine, 2 constant, 3 alternating
        logic signed [16:0] amp;
        logic [8:0]         count;
        logic               jam;
    } scen_t;

    localparam scen_t SCEN [6] = '{
        '{2'd0, 17'sd7,      9'd100, 1'b0},
        '{2'd0, 17'sd99,     9'd240, 1'b1},
        '{2'd1, 17'sd30000,  9'd80,  1'b0},
        '{2'd2, -17'sd32768, 9'd240, 1'b0},
        '{2'd3, 17'sd32767,  9'd80,  1'b0},
        '{2'd1, 17'sd12000,  9'd80,  1'b0}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic        in_ready;
    logic [15:0] in_sample = '0;
    logic        frame_start = 0;
    logic        ac_valid;
    logic [3:0]  ac_lag;
    logic [39:0] ac_value;
    logic        done;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int seed = 1;
    int sidx = 0;
    int hist[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lpc_autocorr i_lpc_autocorr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .frame_start(frame_start), .ac_valid(ac_valid),
        .ac_lag(ac_lag), .ac_value(ac_value), .done(done)
    );

    task automatic check(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int wq(input int n);
        real v;
        int q;
        v = (n < 200) ? 0.54 - 0.46 * $cos(PI2 * n / 399.0) : $cos(PI2 * (n - 200) / 159.0);
        q = int'(v * 32768.0);
        return (q > 32767) ? 32767 : q;
    endfunction

    function automatic void model(output longint r[NL]);
        longint y[WN];
        int t = hist.size();
        for (int n = 0; n < WN; n++) begin
            int idx = t - WN + n;
            longint x = (idx < 0) ? 0 : longint'(hist[idx]);
            y[n] = (x * wq(n) + 16384) >>> 15;
        end
        for (int k = 0; k < NL; k++) begin
            r[k] = 0;
            for (int n = k; n < WN; n++) r[k] += y[n] * y[n - k];
        end
    endfunction

    function automatic int gen(input scen_t s);
        int v;
        case (s.kind)
            2'd0: begin seed = seed * 1103515245 + 12345; v = int'($signed(seed[30:15])); end
            2'd1: v = int'($sin(PI2 * sidx / 37.0) * real'(s.amp));
            2'd2: v = int'(s.amp);
            default: v = sidx[0] ? -int'(s.amp) : int'(s.amp);
        endcase
        sidx++;
        return v;
    endfunction

    task automatic push(input int s);
        @(negedge clk);
        in_valid = 1;
        in_sample = 16'(s);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 0;
        hist.push_back(s);
    endtask

    // Runs/collects one analysis and compares all lags with the model.
    task automatic analyse(input bit strobe, input bit jam, input bit extra);
        longint exp_r[NL];
        longint got_r[NL];
        int nvalid = 0;
        int last_cyc = -10;
        int start_cyc;
        int first_cyc = -1;
        bit fin = 0;
        model(exp_r);
        for (int i = 0; i < NL; i++) got_r[i] = 0;
        if (strobe) begin
            @(negedge clk) frame_start = 1;
            start_cyc = cyc;
            @(negedge clk) frame_start = 0;
            check("R8", "in_ready while windowing", longint'(in_ready), 0);
            if (jam) begin
                in_valid = 1;
                in_sample = 16'h7abc;
                repeat (10) @(negedge clk);
                in_valid = 0;
            end
        end else begin
            start_cyc = cyc - 1;
        end
        while (!fin) begin
            @(negedge clk);
            frame_start = 0;
            if (ac_valid) begin
                if (first_cyc < 0) first_cyc = cyc;
                check("R6", "lag order", longint'(ac_lag), nvalid);
                if (ac_lag < NL) got_r[ac_lag] = longint'($signed(ac_value));
                if (ac_lag == 0 && !extra) check("R8", "in_ready while accumulating", longint'(in_ready), 1);
                if (extra && (ac_lag == 3 || ac_lag == 5)) frame_start = 1;
                nvalid++;
                last_cyc = cyc;
            end
            if (done) begin
                check("R7", "done one cycle after lag 10", cyc - last_cyc, 1);
                fin = 1;
            end
            if (cyc > 190000) fin = 1;
        end
        check("R6", "result count", nvalid, NL);
        if (strobe) check("R10", "latency to first result", first_cyc - start_cyc, 481);
        for (int k = 0; k < NL; k++)
            check(k == 0 ? "R5" : "R2 R3 R4 R5", $sformatf("lag %0d", k), got_r[k], exp_r[k]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "ac_valid after reset", longint'(ac_valid), 0);
        check("R1", "done after reset", longint'(done), 0);
        check("R1", "in_ready after reset", longint'(in_ready), 1);

        // scenario table; first entry also proves zero fill (R1, R2)
        for (int s = 0; s < 6; s++) begin
            for (int i = 0; i < int'(SCEN[s].count); i++) push(gen(SCEN[s]));
            analyse(1'b1, SCEN[s].jam, 1'b0);
        end

        // R9: two strobes during accumulation give exactly one extra analysis
        analyse(1'b1, 1'b0, 1'b1);
        analyse(1'b0, 1'b0, 1'b0);
        begin
            int stray = 0;
            repeat (3000) begin
                @(negedge clk);
                if (ac_valid || done) stray++;
            end
            check("R9", "results after collapsed strobes", stray, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule